// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Unit

This block is an integer datapath for a family of halfword multiply and multiply-accumulate operations. From each of two source words it takes one half, extends it as signed or unsigned, and multiplies the two halves into a full-width product. Two opcode fields decide what happens to that product. It can be written out directly. It can be added to the current destination value, or subtracted from it. The accumulated result can also be checked for signed or unsigned overflow, and clamped to the representable limit.

The unit is combinational from the operands to a single output register stage. A valid strobe marks each result, and the result appears one clock after the operands are presented. Next to the new destination value it returns a write enable and value for the overflow flag and an updated sticky summary-overflow bit. When a record request is made, it also returns a four-bit condition field computed from the final stored value. The surrounding pipeline supplies the register operands and commits the outputs.

Top module: `hw_mac_unit`

## Requirements
- R1: Operand halves are chosen by opc3. Bit 2 set takes the low half of src_a and bit 2 clear takes its high half. Bit 3 does the same for src_b.
- R2: opc3 bit 0 set makes both halves signed, so the product is sign-extended. With bit 0 clear both halves are zero-extended and the product is treated as unsigned.
- R3: With opc2 bit 2 clear (product mode), acc_out is the product alone. The saturation and overflow-report bits are ignored in this mode: ov_we=0, ov_out=0 and so_out=so_in.
- R4: With opc2 bit 2 set (accumulate mode), acc_out is acc_in plus the product. When opc2 bit 1 is also set, acc_out is acc_in minus the product.
- R5: In accumulate mode with opc3 bit 4 set, ov_we=1 and ov_out equals the overflow condition. so_out is so_in OR overflow. In every other case ov_we=0 and ov_out=0, and so_out equals so_in, so SO is never cleared.
- R6: Signed overflow (opc3 bit 0 set) is the condition that acc_in and the product share a sign bit and the raw result's sign bit differs from the sign bit of acc_in.
- R7: In signed accumulate mode with opc3 bit 1 set, an overflowed result is replaced. It becomes 0x7FFFFFFF if acc_in was non-negative and 0x80000000 if acc_in was negative.
- R8: Unsigned overflow (opc3 bit 0 clear) is the condition that the raw result is unsigned-less-than the product. With opc3 bit 1 set in accumulate mode, an overflowed result becomes 0xFFFFFFFF.
- R9: cr_we equals rec_en of the operation. cr_out is {LT, GT, EQ, SO}, with bit 3 = LT. LT, GT and EQ come from a signed compare of the final acc_out with zero, and bit 0 is a copy of so_out.
- R10: All outputs are registered. in_valid sampled at a rising edge gives out_valid=1 with the result after that edge. Without in_valid, out_valid=0 and the other outputs hold. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode fields valid this cycle |
| src_a | input | DATA_W | First source word |
| src_b | input | DATA_W | Second source word |
| acc_in | input | DATA_W | Current destination value |
| opc2 | input | 2 | Bits 2:1 of the operation field: accumulate, negate |
| opc3 | input | 5 | Sub-operation: ov report, B low, A low, saturate, signed |
| so_in | input | 1 | Current summary-overflow bit |
| rec_en | input | 1 | Request a condition-field update |
| out_valid | output | 1 | Result valid |
| acc_out | output | DATA_W | New destination value |
| ov_we | output | 1 | Overflow flag write enable |
| ov_out | output | 1 | New overflow flag value |
| so_out | output | 1 | New summary-overflow bit |
| cr_we | output | 1 | Condition field write enable |
| cr_out | output | 4 | {LT, GT, EQ, SO} of the result |

## Verification
The assertions check four properties on every cycle. The strobe latency holds. A reported overflow always raises SO. Product mode never writes OV. The condition field is one-hot in its compare bits and mirrors SO. Saturated results are also checked: when an overflow is reported, a saturated signed result can only be one of the two signed limits, and a saturated unsigned result can only be all ones. Only the bench's vectors show the arithmetic itself. These cover the six half and signedness pairings, add versus subtract, the exact overflow boundary, the choice of saturation limit from the accumulator's sign, and the zero-result flags.

// File: rtl/hw_mac_pkg.sv
package hw_mac_pkg;

   // decoded control bits of one operation
   typedef struct packed {
      logic accum;      // add or subtract the destination
      logic negate;     // subtract instead of add
      logic ov_rep;     // report overflow
      logic sat;        // clamp on overflow
      logic signed_op;  // signed halves and signed overflow rule
      logic a_low;      // low half of A
      logic b_low;      // low half of B
   } mac_ctl_t;

   function automatic mac_ctl_t decode_ctl(input logic [2:1] o2, input logic [4:0] o3);
      mac_ctl_t c;
      c.accum     = o2[2];
      c.negate    = o2[1];
      c.ov_rep    = o3[4];
      c.b_low     = o3[3];
      c.a_low     = o3[2];
      c.sat       = o3[1];
      c.signed_op = o3[0];
      return c;
   endfunction

endpackage

// File: rtl/hw_mac_mult.sv
module hw_mac_mult #(
   parameter int DATA_W     = 32,
   parameter int MULT_STYLE = 0   // 0: one widened signed multiplier, 1: two multipliers and a mux
) (
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic              a_low,
   input  logic              b_low,
   input  logic              signed_op,
   output logic [DATA_W-1:0] prod
);
   localparam int HALF_W = DATA_W / 2;

   logic [HALF_W-1:0] half_a, half_b;

   assign half_a = a_low ? src_a[HALF_W-1:0] : src_a[DATA_W-1:HALF_W];
   assign half_b = b_low ? src_b[HALF_W-1:0] : src_b[DATA_W-1:HALF_W];

   generate
      if (MULT_STYLE == 0) begin : g_shared
         logic [HALF_W:0]          ext_a, ext_b;
         logic signed [DATA_W-1:0] wide_a, wide_b;
         assign ext_a  = {signed_op & half_a[HALF_W-1], half_a};
         assign ext_b  = {signed_op & half_b[HALF_W-1], half_b};
         assign wide_a = DATA_W'($signed(ext_a));
         assign wide_b = DATA_W'($signed(ext_b));
         assign prod   = wide_a * wide_b;
      end else begin : g_split
         logic [DATA_W-1:0] s_a, s_b, u_a, u_b, p_s, p_u;
         assign s_a  = {{HALF_W{half_a[HALF_W-1]}}, half_a};
         assign s_b  = {{HALF_W{half_b[HALF_W-1]}}, half_b};
         assign u_a  = {{HALF_W{1'b0}}, half_a};
         assign u_b  = {{HALF_W{1'b0}}, half_b};
         assign p_s  = s_a * s_b;
         assign p_u  = u_a * u_b;
         assign prod = signed_op ? p_s : p_u;
      end
   endgenerate

endmodule

// File: rtl/hw_mac_accum.sv
module hw_mac_accum
   import hw_mac_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] prod,
   input  mac_ctl_t          ctl,
   output logic [DATA_W-1:0] result,
   output logic              ovf,
   output logic              ov_we
);
   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] U_MAX = {DATA_W{1'b1}};

   logic [DATA_W-1:0] raw;
   logic              ovf_s, ovf_u, ovf_any;
   logic [DATA_W-1:0] clamp;

   assign raw = ctl.negate ? (acc_in - prod) : (acc_in + prod);

   // signed rule: same sign in, different sign out relative to the accumulator
   assign ovf_s = (acc_in[MSB] == prod[MSB]) && (raw[MSB] != acc_in[MSB]);
   assign ovf_u = raw < prod;
   assign ovf_any = ctl.signed_op ? ovf_s : ovf_u;

   assign clamp = ctl.signed_op ? (acc_in[MSB] ? S_MIN : S_MAX) : U_MAX;

   always_comb begin
      if (!ctl.accum) begin
         result = prod;
      end else if (ctl.sat && ovf_any) begin
         result = clamp;
      end else begin
         result = raw;
      end
   end

   assign ov_we = ctl.accum & ctl.ov_rep;
   assign ovf   = ctl.accum & ovf_any;

endmodule

// File: rtl/hw_mac_flags.sv
module hw_mac_flags #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] value,
   input  logic              so,
   output logic [3:0]        cr
);
   logic neg, zero;

   assign neg  = value[DATA_W-1];
   assign zero = (value == '0);
   assign cr   = {neg, ~neg & ~zero, zero, so};

endmodule

// File: rtl/hw_mac_unit.sv
module hw_mac_unit
   import hw_mac_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MULT_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [2:1]        opc2,
   input  logic [4:0]        opc3,
   input  logic              so_in,
   input  logic              rec_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] acc_out,
   output logic              ov_we,
   output logic              ov_out,
   output logic              so_out,
   output logic              cr_we,
   output logic [3:0]        cr_out
);
   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("hw_mac_unit: DATA_W must be even and at least 4");
      end
      if (MULT_STYLE != 0 && MULT_STYLE != 1) begin : g_bad_style
         $error("hw_mac_unit: MULT_STYLE must be 0 or 1");
      end
   endgenerate

   mac_ctl_t          ctl;
   logic [DATA_W-1:0] prod, result;
   logic              ovf, ovwe_c, so_c;
   logic [3:0]        cr_c;

   assign ctl = decode_ctl(opc2, opc3);

   hw_mac_mult #(.DATA_W(DATA_W), .MULT_STYLE(MULT_STYLE)) u_mult (
      .src_a     (src_a),
      .src_b     (src_b),
      .a_low     (ctl.a_low),
      .b_low     (ctl.b_low),
      .signed_op (ctl.signed_op),
      .prod      (prod)
   );

   hw_mac_accum #(.DATA_W(DATA_W)) u_accum (
      .acc_in (acc_in),
      .prod   (prod),
      .ctl    (ctl),
      .result (result),
      .ovf    (ovf),
      .ov_we  (ovwe_c)
   );

   assign so_c = so_in | (ovwe_c & ovf);

   hw_mac_flags #(.DATA_W(DATA_W)) u_flags (
      .value (result),
      .so    (so_c),
      .cr    (cr_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         acc_out   <= '0;
         ov_we     <= 1'b0;
         ov_out    <= 1'b0;
         so_out    <= 1'b0;
         cr_we     <= 1'b0;
         cr_out    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            acc_out <= result;
            ov_we   <= ovwe_c;
            ov_out  <= ovwe_c & ovf;
            so_out  <= so_c;
            cr_we   <= rec_en;
            cr_out  <= cr_c;
         end
      end
   end

   // R10
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R5
   ov_sets_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ov_out |-> (so_out && ov_we));

   // R3
   product_no_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !opc2[2]) |=> (!ov_we && !ov_out));

   // R9
   cr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |-> ($onehot(cr_out[3:1]) && cr_out[0] == so_out));

   // R7
   signed_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ov_out && $past(opc3[1] && opc3[0])) |->
      (acc_out == {1'b0, {(DATA_W-1){1'b1}}} || acc_out == {1'b1, {(DATA_W-1){1'b0}}}));

   // R8
   unsigned_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ov_out && $past(opc3[1] && !opc3[0])) |-> (acc_out == {DATA_W{1'b1}}));

endmodule

// File: tb/test_hw_mac_unit.sv
module test_hw_mac_unit;

   typedef struct packed {
      logic [3:0]  rq;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] d;
      logic [2:1]  o2;
      logic [4:0]  o3;
      logic        so;
      logic        rec;
      logic [31:0] ed;
      logic        ewe;
      logic        eov;
      logic        eso;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      // R1 R2: low x low signed, -2 * 3
      '{4'd1, 32'h0000FFFE, 32'h00000003, 32'h0, 2'b00, 5'h0D, 1'b0, 1'b1, 32'hFFFFFFFA, 1'b0, 1'b0, 1'b0},
      // R2: low x low unsigned
      '{4'd2, 32'h0000FFFE, 32'h00000003, 32'h0, 2'b00, 5'h0C, 1'b0, 1'b1, 32'h0002FFFA, 1'b0, 1'b0, 1'b0},
      // R1: high x high signed, -32768 squared
      '{4'd1, 32'h80000000, 32'h80001234, 32'h0, 2'b00, 5'h01, 1'b0, 1'b0, 32'h40000000, 1'b0, 1'b0, 1'b0},
      // R2: high x high unsigned
      '{4'd2, 32'hFFFF0000, 32'hFFFF0000, 32'h0, 2'b00, 5'h00, 1'b0, 1'b1, 32'hFFFE0001, 1'b0, 1'b0, 1'b0},
      // R1: low A x high B signed
      '{4'd1, 32'h12340002, 32'hFFFD5678, 32'h0, 2'b00, 5'h05, 1'b0, 1'b1, 32'hFFFFFFFA, 1'b0, 1'b0, 1'b0},
      // R1: low A x high B unsigned
      '{4'd1, 32'h12340002, 32'hFFFD5678, 32'h0, 2'b00, 5'h04, 1'b0, 1'b0, 32'h0001FFFA, 1'b0, 1'b0, 1'b0},
      // R3: product mode ignores sat and ov bits
      '{4'd3, 32'h00007FFF, 32'h00007FFF, 32'h7FFFFFFF, 2'b00, 5'h1F, 1'b1, 1'b1, 32'h3FFF0001, 1'b0, 1'b0, 1'b1},
      // R4 R5: add, ov reported clear, SO stays set
      '{4'd5, 32'h00000002, 32'h00000003, 32'd100, 2'b10, 5'h1D, 1'b1, 1'b1, 32'h0000006A, 1'b1, 1'b0, 1'b1},
      // R6 R7: positive signed overflow clamps high
      '{4'd7, 32'h00007FFF, 32'h00007FFF, 32'h7FFFFFF0, 2'b10, 5'h1F, 1'b0, 1'b1, 32'h7FFFFFFF, 1'b1, 1'b1, 1'b1},
      // R7: negative signed overflow clamps low
      '{4'd7, 32'h00008000, 32'h00007FFF, 32'h80000010, 2'b10, 5'h1F, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b1},
      // R6: overflow reported, no clamp
      '{4'd6, 32'h00007FFF, 32'h00007FFF, 32'h7FFFFFF0, 2'b10, 5'h1D, 1'b0, 1'b1, 32'hBFFEFFF1, 1'b1, 1'b1, 1'b1},
      // R8: unsigned overflow clamps, no report
      '{4'd8, 32'h0000FFFF, 32'h0000FFFF, 32'hFFFFFF00, 2'b10, 5'h0E, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0},
      // R8: unsigned overflow reported, no clamp
      '{4'd8, 32'h0000FFFF, 32'h0000FFFF, 32'hFFFFFF00, 2'b10, 5'h1C, 1'b0, 1'b1, 32'hFFFDFF01, 1'b1, 1'b1, 1'b1},
      // R4: subtract to negative, no report
      '{4'd4, 32'h00000003, 32'h00000004, 32'd10, 2'b11, 5'h0D, 1'b0, 1'b1, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0},
      // R4 R5: subtract, report clear
      '{4'd4, 32'h00000003, 32'h00000004, 32'd100, 2'b11, 5'h1D, 1'b0, 1'b1, 32'h00000058, 1'b1, 1'b0, 1'b0},
      // R9: zero result gives EQ
      '{4'd9, 32'h00000002, 32'h00000003, 32'hFFFFFFFA, 2'b10, 5'h0D, 1'b0, 1'b1, 32'h00000000, 1'b0, 1'b0, 1'b0},
      // R6: just below the signed limit, no overflow
      '{4'd6, 32'h00000001, 32'h00000001, 32'h7FFFFFFE, 2'b10, 5'h1F, 1'b0, 1'b1, 32'h7FFFFFFF, 1'b1, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] src_a = '0, src_b = '0, acc_in = '0;
   logic [2:1]  opc2 = '0;
   logic [4:0]  opc3 = '0;
   logic        so_in = 1'b0, rec_en = 1'b0;
   logic        out_valid, ov_we, ov_out, so_out, cr_we;
   logic [31:0] acc_out;
   logic [3:0]  cr_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hw_mac_unit i_hw_mac_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
      .opc2(opc2), .opc3(opc3), .so_in(so_in), .rec_en(rec_en),
      .out_valid(out_valid), .acc_out(acc_out), .ov_we(ov_we), .ov_out(ov_out),
      .so_out(so_out), .cr_we(cr_we), .cr_out(cr_out)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_cr(input logic [31:0] v, input logic so);
      return {$signed(v) < 0, $signed(v) > 0, v == 0, so};
   endfunction

   initial begin
      #3_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "reset out_valid", {31'b0, out_valid}, 32'h0);
      check("R10", "reset acc_out", acc_out, 32'h0);
      check("R10", "reset flags", {27'b0, ov_we, ov_out, so_out, cr_we, 1'b0}, 32'h0);
      check("R10", "reset cr_out", {28'b0, cr_out}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         src_a = VEC[i].a; src_b = VEC[i].b; acc_in = VEC[i].d;
         opc2 = VEC[i].o2; opc3 = VEC[i].o3; so_in = VEC[i].so; rec_en = VEC[i].rec;
         in_valid = 1'b1;
         @(negedge clk);
         check($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d acc_out", i), acc_out, VEC[i].ed);
         check($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d ov_we/ov/so", i),
               {29'b0, ov_we, ov_out, so_out}, {29'b0, VEC[i].ewe, VEC[i].eov, VEC[i].eso});
         check("R10", $sformatf("vec %0d out_valid", i), {31'b0, out_valid}, 32'h1);
         // R9
         check("R9", $sformatf("vec %0d cr_we", i), {31'b0, cr_we}, {31'b0, VEC[i].rec});
         if (VEC[i].rec)
            check("R9", $sformatf("vec %0d cr_out", i), {28'b0, cr_out}, {28'b0, exp_cr(VEC[i].ed, VEC[i].eso)});
      end

      // R10: idle cycle drops valid and holds the last result
      in_valid = 1'b0;
      src_a = 32'hFFFFFFFF; src_b = 32'hFFFFFFFF; acc_in = 32'h12345678;
      @(negedge clk);
      check("R10", "idle out_valid", {31'b0, out_valid}, 32'h0);
      check("R10", "idle hold acc_out", acc_out, VEC[NV-1].ed);

      // R10: synchronous reset mid-stream clears outputs
      in_valid = 1'b1; opc2 = 2'b00; opc3 = 5'h0D; src_a = 32'h5; src_b = 32'h7;
      @(negedge clk);
      check("R1", "low x low 5*7", acc_out, 32'd35);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check("R10", "reset after run acc_out", acc_out, 32'h0);
      check("R10", "reset after run valid", {31'b0, out_valid}, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule